// File: doc/BRIEF.md
# Four-Function Byte ALU

The block is a purely combinational arithmetic logic unit for two byte operands. A two-bit function select picks one of four results: bitwise AND, bitwise OR, sum, or difference. There is no clock, register or reset inside. The result follows the operands and the select through gate delay alone.

Inside, the block has two sections. The logic section forms the AND and the OR of the operands, and a 2-to-1 multiplexer keeps one of them. The arithmetic section feeds either B or its bitwise complement into a ripple-carry chain of full adders. Its carry-in is the AND of the two select bits, so it is 1 only for subtraction. A final multiplexer, steered by the upper select bit, chooses between the two sections. The carry leaving the top adder stage comes out on its own pin. Results wrap modulo 2^WIDTH, and no flags are produced.

Top module: `alu_quad`

## Requirements
- R1: With `fsel` = 2'b00, `res` equals `opa & opb` bit for bit.
- R2: With `fsel` = 2'b01, `res` equals `opa | opb` bit for bit.
- R3: With `fsel` = 2'b10, `res` equals `(opa + opb) mod 256`.
- R4: With `fsel` = 2'b11, `res` equals `(opa - opb) mod 256`, formed as `opa + ~opb + 1`.
- R5: With `fsel` = 2'b10, `cout` is bit 8 of the 9-bit sum `opa + opb`.
- R6: With `fsel` = 2'b11, `cout` is 1 exactly when `opa >= opb` (no borrow).
- R7: In the logic modes, `cout` still shows the adder's carry with carry-in 0. The adder adds `opb` when `fsel` = 2'b00 and `~opb` when `fsel` = 2'b01. So `cout` = bit 8 of `opa + opb` for 2'b00, and `cout` = 1 exactly when `opa > opb` for 2'b01. `cout` does not change `res`.
- R8: The fixed vectors give these results: 0x61 + 0x57 = 0xB8, 0xB5 - 0x3E = 0x77, 0xC2 AND 0x6D = 0x40, 0xC2 OR 0x61 = 0xE3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| fsel | input | 2 | Function select: bit 1 picks arithmetic (1) or logic (0); bit 0 picks OR/subtract (1) or AND/add (0) |
| res | output | WIDTH | Selected result |
| cout | output | 1 | Carry out of the top adder stage |

## Verification
All four select codes are applied over every pair of byte operands. Such a sweep includes zero, all-ones, equal operands and every carry-propagation length in the ripple chain. Equal operands separate the `>=` carry of subtraction from the `>` carry of the OR mode. An all-ones operand paired with one exercises the longest ripple in addition. The fixed vectors pin the select decoding against known answers, so an error in the multiplexer order shows up even when the arithmetic itself is right.

// File: rtl/alu_quad.sv
module alu_quad #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [1:0]       fsel,
  output logic [WIDTH-1:0] res,
  output logic             cout
);

  logic             is_math;
  logic             alt_op;
  logic [WIDTH-1:0] and_v;
  logic [WIDTH-1:0] or_v;
  logic [WIDTH-1:0] logic_v;
  logic [WIDTH-1:0] b_inv;
  logic [WIDTH-1:0] b_add;
  logic [WIDTH-1:0] sum_v;
  logic [WIDTH:0]   rip;

  assign is_math = fsel[1];
  assign alt_op  = fsel[0];

  assign and_v   = opa & opb;
  assign or_v    = opa | opb;
  assign logic_v = alt_op ? or_v : and_v;

  assign b_inv   = ~opb;
  assign b_add   = alt_op ? b_inv : opb;
  assign rip[0]  = is_math & alt_op;

  for (genvar i = 0; i < WIDTH; i++) begin : g_fa
    logic p;
    assign p        = opa[i] ^ b_add[i];
    assign sum_v[i] = p ^ rip[i];
    assign rip[i+1] = (opa[i] & b_add[i]) | (p & rip[i]);
  end

  assign res  = is_math ? sum_v : logic_v;
  assign cout = rip[WIDTH];

endmodule

module alu_quad_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic [1:0]       fsel,
  input logic [WIDTH-1:0] res,
  input logic             cout
);

  logic [WIDTH-1:0] back;
  assign back = res - opb;

  always_comb begin
    if (fsel == 2'b00) begin
      assert_and_subset_R1: assert (((res & ~opa) == '0) && ((res & ~opb) == '0) && ((res | ~(opa & opb)) == '1));
    end
    if (fsel == 2'b01) begin
      assert_or_cover_R2: assert (((res & opa) == opa) && ((res & opb) == opb) && ((res & ~opa & ~opb) == '0));
    end
    if (fsel == 2'b10) begin
      assert_add_inverse_R3: assert (back == opa);
    end
    if (fsel == 2'b11) begin
      assert_sub_inverse_R4: assert (WIDTH'(res + opb) == opa);
      assert_no_borrow_R6: assert (cout == (opa >= opb));
    end
    if (fsel == 2'b10) begin
      assert_add_carry_R5: assert (cout == (res < opa));
    end
    if (fsel == 2'b01) begin
      assert_logic_carry_R7: assert (cout == (opa > opb));
    end
  end

endmodule

bind alu_quad alu_quad_chk #(.WIDTH(WIDTH)) u_chk (
  .opa(opa), .opb(opb), .fsel(fsel), .res(res), .cout(cout)
);

// File: tb/sim_alu_quad.sv
module sim_alu_quad;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic [1:0]   f = 2'b00;
  logic [W-1:0] r;
  logic         c;

  int n_cmp = 0;
  int n_bad = 0;
  int wd    = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  alu_quad #(.WIDTH(W)) u0 (.opa(a), .opb(b), .fsel(f), .res(r), .cout(c));

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s a=%02h b=%02h f=%0d actual=%0h expected=%0h", tag, a, b, f, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic apply(input int va, input int vb, input int vf);
    a = W'(va);
    b = W'(vb);
    f = 2'(vf);
    #1;
  endtask

  always @(posedge clk) begin
    if (!rst) begin
      wd <= wd + 1;
      if (wd > 100000) begin
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);

    // idle state: all-zero inputs give AND result 0, carry 0 (R1, R7)
    apply(0, 0, 0);
    chk("R1 idle res", int'(r), 0);
    chk("R7 idle cout", int'(c), 0);

    // R8 fixed vectors
    apply(8'h61, 8'h57, 2);  chk("R8 add", int'(r), 8'hB8);
    apply(8'hB5, 8'h3E, 3);  chk("R8 sub", int'(r), 8'h77);
    apply(8'hC2, 8'h6D, 0);  chk("R8 and", int'(r), 8'h40);
    apply(8'hC2, 8'h61, 1);  chk("R8 or",  int'(r), 8'hE3);

    // exhaustive sweep
    for (int fv = 0; fv < 4; fv++) begin
      for (int av = 0; av < 256; av++) begin
        for (int bv = 0; bv < 256; bv++) begin
          apply(av, bv, fv);
          case (fv)
            0: begin
              chk("R1 and", int'(r), av & bv);
              chk("R7 cout and-mode", int'(c), ((av + bv) >> 8) & 1);
            end
            1: begin
              chk("R2 or", int'(r), av | bv);
              chk("R7 cout or-mode", int'(c), (av > bv) ? 1 : 0);
            end
            2: begin
              chk("R3 add", int'(r), (av + bv) % 256);
              chk("R5 add carry", int'(c), ((av + bv) >> 8) & 1);
            end
            default: begin
              chk("R4 sub", int'(r), (av - bv + 256) % 256);
              chk("R6 sub carry", int'(c), (av >= bv) ? 1 : 0);
            end
          endcase
        end
      end
    end

    finish_run();
  end
endmodule